// File: doc/BRIEF.md
# Associative Page Table Translator

This block turns a 14-bit virtual word address into a 13-bit physical address through a small table searched by content. The upper three address bits name one of eight virtual pages and the lower eleven bits select a word within a 2K-word page. The table holds page-to-block pairs, each with a valid flag. Every entry is compared against the requested page at the same time, and the block number of the matching entry replaces the page number. When no valid entry holds the page, the block reports a page fault instead of an address.

A lookup is started by pulsing `req` with an address. One cycle later `rsp_valid` pulses, and the physical address and fault flag are presented. These results stay unchanged until the next request. Software or a fault handler rewrites entries through a single write port that carries an index, a page, a block and a valid bit.

Top module: `apt_translator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rsp_valid`, `rsp_fault` and `rsp_paddr` are all zero.
- R2: After reset the table maps page 0 to block 3, page 2 to block 1, page 5 to block 2 and page 6 to block 0 (entries 0 to 3 in that order). Pages 1, 3, 4 and 7 are absent.
- R3: The page number is `vaddr[13:11]`. On a hit, `rsp_paddr` equals `{block, vaddr[10:0]}`, with the offset passed through unchanged.
- R4: A page that no valid entry holds sets `rsp_fault` to 1, and `rsp_paddr` then reads 0.
- R5: `rsp_valid` is high for exactly the one cycle that follows each cycle in which `req` is high, and is low otherwise.
- R6: While `req` stays low, `rsp_fault` and `rsp_paddr` keep the values of the last response.
- R7: With `wr_en` high at a clock edge, entry `wr_idx` takes `wr_page`, `wr_block` and `wr_valid`. Later lookups use the new contents.
- R8: An entry written with `wr_valid` = 0 never matches, even if its page field equals the requested page.
- R9: When several valid entries hold the same page, the block of the lowest-index entry is used.
- R10: A write in the same cycle as a lookup request does not affect that lookup. It is seen from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Lookup request, one cycle per lookup |
| vaddr | input | 14 | Virtual word address: page in [13:11], offset in [10:0] |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 2 | Entry index to write |
| wr_page | input | 3 | Page number to store |
| wr_block | input | 2 | Block number to store |
| wr_valid | input | 1 | Valid flag to store |
| rsp_valid | output | 1 | One-cycle pulse marking a new result |
| rsp_fault | output | 1 | Page fault for the last request |
| rsp_paddr | output | 13 | Physical address for the last request, 0 on a fault |

## Verification
Every one of the eight pages is looked up with offsets of zero, one, all ones, the top bit alone and two alternating patterns. This separates offset corruption from block substitution and covers both hits and faults. The same sweep is repeated after the table is rewritten, so a design that hardwires the reset mapping gives wrong results. Directed sequences then place the same page in two entries and invalidate the lower one, which shows whether the priority order is correct. A write issued together with a lookup is followed by a second lookup of the same page, which shows when the new contents take effect. Idle cycles after a response show whether the results are held.

// File: rtl/apt_pkg.sv
package apt_pkg;

    localparam int OFFSET_W = 11;
    localparam int PAGE_W   = 3;
    localparam int BLOCK_W  = 2;
    localparam int VA_W     = PAGE_W + OFFSET_W;
    localparam int PA_W     = BLOCK_W + OFFSET_W;

    typedef struct packed {
        logic               valid;
        logic [PAGE_W-1:0]  page;
        logic [BLOCK_W-1:0] block;
    } entry_t;

    typedef struct packed {
        logic            valid;
        logic            fault;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    // Power-up mapping of the table; indices beyond the list start empty.
    function automatic entry_t reset_entry(input int idx);
        entry_t e;
        e = '0;
        case (idx)
            0: e = '{valid: 1'b1, page: PAGE_W'(0), block: BLOCK_W'(3)};
            1: e = '{valid: 1'b1, page: PAGE_W'(2), block: BLOCK_W'(1)};
            2: e = '{valid: 1'b1, page: PAGE_W'(5), block: BLOCK_W'(2)};
            3: e = '{valid: 1'b1, page: PAGE_W'(6), block: BLOCK_W'(0)};
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/apt_entry_store.sv
module apt_entry_store
    import apt_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [PAGE_W-1:0]          wr_page,
    input  logic [BLOCK_W-1:0]         wr_block,
    input  logic                       wr_valid,
    output entry_t [ENTRIES-1:0]       table_o
);

    entry_t [ENTRIES-1:0] table_d, table_q;

    always_comb begin
        table_d = table_q;
        if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    table_d[i].valid = wr_valid;
                    table_d[i].page  = wr_page;
                    table_d[i].block = wr_block;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                table_q[i] <= reset_entry(i);
            end
        end else begin
            table_q <= table_d;
        end
    end

    assign table_o = table_q;

endmodule

// File: rtl/apt_match.sv
module apt_match
    import apt_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  entry_t [ENTRIES-1:0] table_i,
    input  logic [PAGE_W-1:0]    page_i,
    output logic                 hit_o,
    output logic [BLOCK_W-1:0]   block_o
);

    logic [ENTRIES-1:0] hit_vec;

    // One comparator per entry, all evaluated together.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = table_i[g].valid && (table_i[g].page == page_i);
    end

    // Lowest index wins: scan downward so the last assignment is the smallest hit.
    always_comb begin
        hit_o   = |hit_vec;
        block_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                block_o = table_i[i].block;
            end
        end
    end

endmodule

// File: rtl/apt_translator.sv
module apt_translator
    import apt_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [VA_W-1:0]     vaddr,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [PAGE_W-1:0]   wr_page,
    input  logic [BLOCK_W-1:0]  wr_block,
    input  logic                wr_valid,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [PA_W-1:0]     rsp_paddr
);

    entry_t [ENTRIES-1:0] table_cur;
    logic                 hit;
    logic [BLOCK_W-1:0]   hit_block;
    rsp_t                 rsp_d, rsp_q;

    apt_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_page  (wr_page),
        .wr_block (wr_block),
        .wr_valid (wr_valid),
        .table_o  (table_cur)
    );

    apt_match #(.ENTRIES(ENTRIES)) u_match (
        .table_i (table_cur),
        .page_i  (vaddr[VA_W-1:OFFSET_W]),
        .hit_o   (hit),
        .block_o (hit_block)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req;
        if (req) begin
            rsp_d.fault = !hit;
            rsp_d.paddr = hit ? {hit_block, vaddr[OFFSET_W-1:0]} : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;

endmodule

// File: rtl/apt_translator_chk.sv
module apt_translator_chk
    import apt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic [VA_W-1:0] vaddr,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr
);

    a_r5_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);

    a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);

    a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(rsp_fault) && $stable(rsp_paddr)));

    a_r3_offset_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (rsp_fault || rsp_paddr[OFFSET_W-1:0] == $past(vaddr[OFFSET_W-1:0])));

    a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));

endmodule

bind apt_translator apt_translator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .vaddr     (vaddr),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/apt_translator_test.sv
`timescale 1ns/1ps
module apt_translator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [13:0] vaddr = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [2:0]  wr_page = '0;
    logic [1:0]  wr_block = '0;
    logic        wr_valid = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [12:0] rsp_paddr;

    int checks = 0;
    int errors = 0;

    logic       m_v [4];
    logic [2:0] m_p [4];
    logic [1:0] m_b [4];

    always #4 clk = ~clk;

    apt_translator uut (
        .clk(clk), .rst_n(rst_n), .req(req), .vaddr(vaddr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_page(wr_page),
        .wr_block(wr_block), .wr_valid(wr_valid),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    // Model: first valid entry with the page, lowest index first (R9).
    task automatic model(input logic [13:0] va, output logic f, output logic [12:0] pa);
        f  = 1'b1;
        pa = '0;
        for (int i = 3; i >= 0; i--) begin
            if (m_v[i] && m_p[i] == va[13:11]) begin
                f  = 1'b0;
                pa = {m_b[i], va[10:0]};
            end
        end
    endtask

    task automatic lookup(input logic [13:0] va, input string tag);
        logic f;
        logic [12:0] pa;
        model(va, f, pa);
        @(negedge clk);
        req = 1'b1; vaddr = va;
        @(negedge clk);
        req = 1'b0;
        check({tag, " R5 valid"}, 16'(rsp_valid), 16'd1);
        check({tag, " R4 fault"}, 16'(rsp_fault), 16'(f));
        check({tag, " R3 paddr"}, 16'(rsp_paddr), 16'(pa));
    endtask

    task automatic write_entry(input int idx, input int pg, input int blk, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(idx); wr_page = 3'(pg); wr_block = 2'(blk); wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_v[idx] = v; m_p[idx] = 3'(pg); m_b[idx] = 2'(blk);
    endtask

    task automatic sweep(input string tag);
        logic [10:0] offs [6];
        offs[0] = 11'h000; offs[1] = 11'h001; offs[2] = 11'h7FF;
        offs[3] = 11'h400; offs[4] = 11'h555; offs[5] = 11'h2AA;
        for (int p = 0; p < 8; p++) begin
            for (int o = 0; o < 6; o++) begin
                lookup({3'(p), offs[o]}, tag);
            end
        end
    endtask

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic f_old, f_keep;
        logic [12:0] pa_old, pa_keep;
        // R2 reset contents
        m_v[0] = 1; m_p[0] = 0; m_b[0] = 3;
        m_v[1] = 1; m_p[1] = 2; m_b[1] = 1;
        m_v[2] = 1; m_p[2] = 5; m_b[2] = 2;
        m_v[3] = 1; m_p[3] = 6; m_b[3] = 0;

        @(negedge clk);
        check("R1 reset valid", 16'(rsp_valid), 16'd0);
        check("R1 reset fault", 16'(rsp_fault), 16'd0);
        check("R1 reset paddr", 16'(rsp_paddr), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", 16'(rsp_valid), 16'd0);
        check("R1 after reset paddr", 16'(rsp_paddr), 16'd0);

        sweep("R2 reset table");

        // R6: outputs held across idle cycles
        lookup(14'h2ABC, "R6 setup");
        f_keep = rsp_fault; pa_keep = rsp_paddr;
        repeat (3) @(negedge clk);
        check("R6 hold valid low", 16'(rsp_valid), 16'd0);
        check("R6 hold fault", 16'(rsp_fault), 16'(f_keep));
        check("R6 hold paddr", 16'(rsp_paddr), 16'(pa_keep));

        // R7: rewrite entries
        write_entry(1, 3, 2, 1'b1);
        lookup(14'h1ABC, "R7 new page 3");
        lookup(14'h1123, "R7 old page 2 gone");
        // R8: invalidate entry holding page 6
        write_entry(3, 6, 1, 1'b0);
        lookup(14'h3001, "R8 invalid entry");
        // R9: duplicate page 0 in entry 2
        write_entry(2, 0, 1, 1'b1);
        lookup(14'h0123, "R9 lowest index");
        write_entry(0, 0, 3, 1'b0);
        lookup(14'h0123, "R9 next entry");

        // R10: write alongside lookup of page 7
        model(14'h3F00, f_old, pa_old);
        @(negedge clk);
        req = 1'b1; vaddr = 14'h3F00;
        wr_en = 1'b1; wr_idx = 2'd3; wr_page = 3'd7; wr_block = 2'd0; wr_valid = 1'b1;
        @(negedge clk);
        req = 1'b0; wr_en = 1'b0;
        m_v[3] = 1; m_p[3] = 7; m_b[3] = 0;
        check("R10 same-cycle fault", 16'(rsp_fault), 16'(f_old));
        check("R10 same-cycle paddr", 16'(rsp_paddr), 16'(pa_old));
        lookup(14'h3F00, "R10 after write");

        sweep("R7 rewritten table");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule